// File: doc/BRIEF.md
# Flag-Producing 8-bit ALU

This block is the combinational datapath core of a small accumulator processor. In one pass it computes the data result and the updated sign (N), overflow (V), zero (Z) and carry (C) flags. It covers add and subtract with carry, the three bitwise operations, shifts and rotates, compare, bit test, increment and decrement, and the fused read-modify-write operations. Each fused operation first changes the memory operand and then combines the changed value with the accumulator.

The surrounding sequencer supplies an operation code, the accumulator (or index register for compares), the X register, the memory operand and the current flags. It gets back three things. The first is a register result. The second is a write-back value for memory. The third is the merged flag vector, together with a per-flag write-enable mask that shows which flags the operation defines. The flag vector is ordered bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. Decimal arithmetic is not provided. The data width is the parameter `W`, which defaults to 8.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add) gives res = a + m + C_in mod 256. C is set when the 9-bit sum exceeds 0xFF. V is set when a and m share a sign bit and the result's sign bit differs from a. N is result bit 7 and Z is set when the result is zero. The mask is 0xF.
- R2: Code 1 (subtract) gives res = a + ~m + C_in, which is a - m - (1 - C_in). C is set when no borrow occurs and V flags signed overflow. N and Z follow the result and the mask is 0xF.
- R3: Codes 2, 3 and 4 (AND, OR, XOR of a with m) update only N and Z, with mask 0xA. C and V keep their incoming values.
- R4: Code 5 (shift left) and code 6 (logical shift right) act on m. The bit shifted out goes to C. The result also appears on wb. Code 6 always leaves N clear. The mask is 0xB.
- R5: Code 7 (rotate left) puts C_in into bit 0, and code 8 (rotate right) puts C_in into bit 7. The bit shifted out goes to C, and the mask is 0xB.
- R6: Code 9 (compare) sets C when m <= a and takes N and Z from a - m. It returns res = a and wb = m, with mask 0xB.
- R7: Code 10 (bit test) copies m bit 7 into N and m bit 6 into V. It sets Z when (a AND m) is zero and returns res = a. The mask is 0xE.
- R8: Code 11 (increment) and code 12 (decrement) give m + 1 or m - 1 modulo 256 on both res and wb. Only N and Z are written (mask 0xA).
- R9: Code 13 writes wb = m - 1 and then compares a with it as in R6, keeping res = a. Code 14 writes wb = m + 1 and then subtracts it from a with borrow as in R2.
- R10: Codes 15 to 18 first shift or rotate m and write the shifted value to wb. Code 15 shifts left and then ORs with a. Code 16 rotates left and then ANDs with a. Code 17 shifts right and then XORs with a. For these three, C is the bit shifted out and the mask is 0xB. Code 18 rotates right and then adds to a, using the bit shifted out as the carry into the add. C and V come from that add and the mask is 0xF.
- R11: Code 19 returns m on res and sets N and Z from it (mask 0xA). Code 20 returns wb = a AND x, res = a, and mask 0.
- R12: A flag whose mask bit is 0 leaves flag_o equal to flag_i. Codes 21 to 31 return res = a and wb = m with mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | W | Accumulator or register operand |
| x_i | input | W | X register, used by the AND-store code |
| m_i | input | W | Memory operand |
| flag_i | input | 4 | Incoming flags {N,V,Z,C} |
| res_o | output | W | Register result |
| wb_o | output | W | Memory write-back value |
| flag_o | output | 4 | Flags after the operation |
| we_o | output | 4 | Per-flag write enable {N,V,Z,C} |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with no register in between. The bench applies all inputs together just after a falling clock edge and samples one time unit later, well before the next rising edge. This means no check can see a half-applied operand set. Fixed cases pin the sign, carry and borrow boundaries. A sweep compares add and subtract against an integer model that is written in signed terms rather than as bit logic.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int unsigned OP_W = 5;
  localparam int unsigned FL_W = 4;
  localparam int unsigned FB_N = 3;
  localparam int unsigned FB_V = 2;
  localparam int unsigned FB_Z = 1;
  localparam int unsigned FB_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_AND    = 5'd2,
    OP_OR     = 5'd3,
    OP_XOR    = 5'd4,
    OP_SHL    = 5'd5,
    OP_SHR    = 5'd6,
    OP_ROL    = 5'd7,
    OP_ROR    = 5'd8,
    OP_CMP    = 5'd9,
    OP_TST    = 5'd10,
    OP_INC    = 5'd11,
    OP_DEC    = 5'd12,
    OP_DECCMP = 5'd13,
    OP_INCSUB = 5'd14,
    OP_SHLOR  = 5'd15,
    OP_ROLAND = 5'd16,
    OP_SHRXOR = 5'd17,
    OP_RORADD = 5'd18,
    OP_LDBOTH = 5'd19,
    OP_STAND  = 5'd20
  } alu_op_e;

  typedef enum logic [1:0] {TS_MEM, TS_SHIFT, TS_INC, TS_DEC} tsrc_e;
  typedef enum logic [1:0] {BL_AND, BL_OR, BL_XOR} bool_e;
  typedef enum logic [1:0] {CI_FLAG, CI_ONE, CI_SHIFT} cin_e;
  typedef enum logic [1:0] {RS_ACC, RS_SUM, RS_BOOL, RS_TMP} rsel_e;
  typedef enum logic [1:0] {FS_RES, FS_SUM, FS_TST} fsel_e;

  typedef struct packed {
    tsrc_e           tsrc;
    logic            sh_right;
    logic            sh_rot;
    bool_e           bsel;
    logic            add_inv;
    cin_e            cin;
    rsel_e           rsel;
    fsel_e           fsel;
    logic            c_shift;
    logic            wb_and;
    logic [FL_W-1:0] we;
  } ctrl_t;

  localparam logic [FL_W-1:0] WE_NZ   = 4'b1010;
  localparam logic [FL_W-1:0] WE_NZC  = 4'b1011;
  localparam logic [FL_W-1:0] WE_NVZ  = 4'b1110;
  localparam logic [FL_W-1:0] WE_ALL  = 4'b1111;
  localparam logic [FL_W-1:0] WE_NONE = 4'b0000;

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
  import flag_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctl_o
);

  always_comb begin
    ctl_o          = '0;
    ctl_o.tsrc     = TS_MEM;
    ctl_o.bsel     = BL_AND;
    ctl_o.cin      = CI_FLAG;
    ctl_o.rsel     = RS_ACC;
    ctl_o.fsel     = FS_RES;
    ctl_o.we       = WE_NONE;
    case (op_i)
      OP_ADD: begin
        ctl_o.rsel = RS_SUM; ctl_o.we = WE_ALL;
      end
      OP_SUB: begin
        ctl_o.add_inv = 1'b1; ctl_o.rsel = RS_SUM; ctl_o.we = WE_ALL;
      end
      OP_AND: begin
        ctl_o.bsel = BL_AND; ctl_o.rsel = RS_BOOL; ctl_o.we = WE_NZ;
      end
      OP_OR: begin
        ctl_o.bsel = BL_OR; ctl_o.rsel = RS_BOOL; ctl_o.we = WE_NZ;
      end
      OP_XOR: begin
        ctl_o.bsel = BL_XOR; ctl_o.rsel = RS_BOOL; ctl_o.we = WE_NZ;
      end
      OP_SHL: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.rsel = RS_TMP;
        ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_SHR: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_right = 1'b1; ctl_o.rsel = RS_TMP;
        ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_ROL: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_rot = 1'b1; ctl_o.rsel = RS_TMP;
        ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_ROR: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_right = 1'b1; ctl_o.sh_rot = 1'b1;
        ctl_o.rsel = RS_TMP; ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_CMP: begin
        ctl_o.add_inv = 1'b1; ctl_o.cin = CI_ONE; ctl_o.fsel = FS_SUM;
        ctl_o.we = WE_NZC;
      end
      OP_TST: begin
        ctl_o.bsel = BL_AND; ctl_o.fsel = FS_TST; ctl_o.we = WE_NVZ;
      end
      OP_INC: begin
        ctl_o.tsrc = TS_INC; ctl_o.rsel = RS_TMP; ctl_o.we = WE_NZ;
      end
      OP_DEC: begin
        ctl_o.tsrc = TS_DEC; ctl_o.rsel = RS_TMP; ctl_o.we = WE_NZ;
      end
      OP_DECCMP: begin
        ctl_o.tsrc = TS_DEC; ctl_o.add_inv = 1'b1; ctl_o.cin = CI_ONE;
        ctl_o.fsel = FS_SUM; ctl_o.we = WE_NZC;
      end
      OP_INCSUB: begin
        ctl_o.tsrc = TS_INC; ctl_o.add_inv = 1'b1; ctl_o.rsel = RS_SUM;
        ctl_o.we = WE_ALL;
      end
      OP_SHLOR: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.bsel = BL_OR; ctl_o.rsel = RS_BOOL;
        ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_ROLAND: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_rot = 1'b1; ctl_o.bsel = BL_AND;
        ctl_o.rsel = RS_BOOL; ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_SHRXOR: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_right = 1'b1; ctl_o.bsel = BL_XOR;
        ctl_o.rsel = RS_BOOL; ctl_o.c_shift = 1'b1; ctl_o.we = WE_NZC;
      end
      OP_RORADD: begin
        ctl_o.tsrc = TS_SHIFT; ctl_o.sh_right = 1'b1; ctl_o.sh_rot = 1'b1;
        ctl_o.cin = CI_SHIFT; ctl_o.rsel = RS_SUM; ctl_o.we = WE_ALL;
      end
      OP_LDBOTH: begin
        ctl_o.rsel = RS_TMP; ctl_o.we = WE_NZ;
      end
      OP_STAND: begin
        ctl_o.wb_and = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  function automatic logic [W:0] wide_sum(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic sign_ovf(input logic as, input logic bs,
                                    input logic rs);
    return (as == bs) && (rs != as);
  endfunction

  logic [W:0] full;

  always_comb begin
    full   = wide_sum(a_i, b_i, cin_i);
    sum_o  = full[W-1:0];
    cout_o = full[W];
    ovf_o  = sign_ovf(a_i[W-1], b_i[W-1], full[W-1]);
  end

endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
  parameter int W = 8
) (
  input  logic         right_i,
  input  logic         rot_i,
  input  logic [W-1:0] din_i,
  input  logic         cin_i,
  output logic [W-1:0] dout_o,
  output logic         cout_o
);

  logic fill;

  always_comb begin
    fill = rot_i & cin_i;
    if (right_i) begin
      dout_o = {fill, din_i[W-1:1]};
      cout_o = din_i[0];
    end else begin
      dout_o = {din_i[W-2:0], fill};
      cout_o = din_i[W-1];
    end
  end

endmodule

// File: rtl/flag_alu_bool.sv
module flag_alu_bool
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  bool_e        sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    case (sel_i)
      BL_OR:   y_o = a_i | b_i;
      BL_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    x_i,
  input  logic [W-1:0]    m_i,
  input  logic [FL_W-1:0] flag_i,
  output logic [W-1:0]    res_o,
  output logic [W-1:0]    wb_o,
  output logic [FL_W-1:0] flag_o,
  output logic [FL_W-1:0] we_o
);

  localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] step_val(input logic [W-1:0] v,
                                            input logic down);
    return down ? (v - UNIT) : (v + UNIT);
  endfunction

  ctrl_t          ctl;
  logic [W-1:0]   sh_val;
  logic           sh_cout;
  logic [W-1:0]   t_val;
  logic [W-1:0]   add_b;
  logic           add_cin;
  logic [W-1:0]   sum_val;
  logic           add_cout;
  logic           add_ovf;
  logic [W-1:0]   bool_val;
  logic [FL_W-1:0] calc;

  flag_alu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  flag_alu_shift #(.W(W)) u_sh (
    .right_i (ctl.sh_right),
    .rot_i   (ctl.sh_rot),
    .din_i   (m_i),
    .cin_i   (flag_i[FB_C]),
    .dout_o  (sh_val),
    .cout_o  (sh_cout)
  );

  always_comb begin
    case (ctl.tsrc)
      TS_SHIFT: t_val = sh_val;
      TS_INC:   t_val = step_val(m_i, 1'b0);
      TS_DEC:   t_val = step_val(m_i, 1'b1);
      default:  t_val = m_i;
    endcase
    add_b = ctl.add_inv ? ~t_val : t_val;
    case (ctl.cin)
      CI_ONE:   add_cin = 1'b1;
      CI_SHIFT: add_cin = sh_cout;
      default:  add_cin = flag_i[FB_C];
    endcase
  end

  flag_alu_adder #(.W(W)) u_add (
    .a_i    (a_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (sum_val),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  flag_alu_bool #(.W(W)) u_bool (
    .sel_i (ctl.bsel),
    .a_i   (a_i),
    .b_i   (t_val),
    .y_o   (bool_val)
  );

  always_comb begin
    case (ctl.rsel)
      RS_SUM:  res_o = sum_val;
      RS_BOOL: res_o = bool_val;
      RS_TMP:  res_o = t_val;
      default: res_o = a_i;
    endcase
    wb_o = ctl.wb_and ? (a_i & x_i) : t_val;
  end

  always_comb begin
    case (ctl.fsel)
      FS_SUM: begin
        calc[FB_N] = sum_val[W-1];
        calc[FB_Z] = (sum_val == ZERO);
        calc[FB_V] = add_ovf;
      end
      FS_TST: begin
        calc[FB_N] = m_i[W-1];
        calc[FB_Z] = (bool_val == ZERO);
        calc[FB_V] = m_i[W-2];
      end
      default: begin
        calc[FB_N] = res_o[W-1];
        calc[FB_Z] = (res_o == ZERO);
        calc[FB_V] = add_ovf;
      end
    endcase
    calc[FB_C] = ctl.c_shift ? sh_cout : add_cout;
    we_o   = ctl.we;
    flag_o = (calc & ctl.we) | (flag_i & ~ctl.we);
  end

endmodule

// File: rtl/flag_alu_check.sv
module flag_alu_check
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    x_i,
  input logic [W-1:0]    m_i,
  input logic [FL_W-1:0] flag_i,
  input logic [W-1:0]    res_o,
  input logic [W-1:0]    wb_o,
  input logic [FL_W-1:0] flag_o,
  input logic [FL_W-1:0] we_o,
  input logic            add_cout,
  input logic            sh_cout
);

  localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    assert_keep_flags_R12: assert (((flag_o ^ flag_i) & ~we_o) == '0)
      else $error("unmasked flag changed");
    if (op_i == OP_ADD)
      assert_add_zero_R1: assert (flag_o[FB_Z] == (res_o == '0) && flag_o[FB_C] == add_cout)
        else $error("add Z/C mismatch");
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
      assert_logic_no_cv_R3: assert (!we_o[FB_C] && !we_o[FB_V])
        else $error("logic op writes C or V");
    if (op_i == OP_SHR)
      assert_shr_clears_n_R4: assert (!flag_o[FB_N] && flag_o[FB_C] == m_i[0] && flag_o[FB_C] == sh_cout)
        else $error("shift right N/C wrong");
    if (op_i == OP_CMP)
      assert_cmp_keeps_reg_R6: assert (res_o == a_i && wb_o == m_i && flag_o[FB_C] == (m_i <= a_i))
        else $error("compare changed register or C wrong");
    if (op_i == OP_TST)
      assert_tst_copies_R7: assert (flag_o[FB_N] == m_i[W-1] && flag_o[FB_V] == m_i[W-2])
        else $error("bit test N/V wrong");
    if (op_i == OP_INC)
      assert_inc_wrap_R8: assert (wb_o == m_i + UNIT && res_o == wb_o)
        else $error("increment value wrong");
    if (op_i == OP_STAND)
      assert_store_noflag_R11: assert (we_o == '0 && wb_o == (a_i & x_i))
        else $error("AND-store wrong");
  end

endmodule

bind flag_alu flag_alu_check #(.W(W)) u_chk (
  .op_i     (op_i),
  .a_i      (a_i),
  .x_i      (x_i),
  .m_i      (m_i),
  .flag_i   (flag_i),
  .res_o    (res_o),
  .wb_o     (wb_o),
  .flag_o   (flag_o),
  .we_o     (we_o),
  .add_cout (add_cout),
  .sh_cout  (sh_cout)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;

  logic       clk;
  logic [4:0] op;
  logic [7:0] a, x, m;
  logic [3:0] fin;
  logic [7:0] res, wb;
  logic [3:0] fout, we;
  int         n_tests;
  int         n_fail;
  bit         done;

  flag_alu #(.W(8)) uut (
    .op_i (op), .a_i (a), .x_i (x), .m_i (m), .flag_i (fin),
    .res_o (res), .wb_o (wb), .flag_o (fout), .we_o (we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply(input logic [4:0] o, input logic [7:0] av,
                       input logic [7:0] xv, input logic [7:0] mv,
                       input logic [3:0] fv);
    @(negedge clk);
    op = o; a = av; x = xv; m = mv; fin = fv;
    #1;
  endtask

  task automatic expect4(input string tag, input logic [7:0] er,
                         input logic [7:0] ew, input logic [3:0] ef,
                         input logic [3:0] ee);
    n_tests++;
    if (res !== er || wb !== ew || fout !== ef || we !== ee) begin
      n_fail++;
      $display("FAIL %s: res=%h wb=%h flags=%b we=%b, expected res=%h wb=%h flags=%b we=%b",
               tag, res, wb, fout, we, er, ew, ef, ee);
    end
  endtask

  task automatic t_reset_state;
    apply(5'd0, 8'h00, 8'h00, 8'h00, 4'b0000);
    expect4("R1 idle zero", 8'h00, 8'h00, 4'b0010, 4'b1111);
  endtask

  task automatic t_add;
    apply(5'd0, 8'h50, 8'h00, 8'h50, 4'b0000);
    expect4("R1 signed overflow", 8'hA0, 8'h50, 4'b1100, 4'b1111);
    apply(5'd0, 8'hFF, 8'h00, 8'h01, 4'b0000);
    expect4("R1 carry out", 8'h00, 8'h01, 4'b0011, 4'b1111);
  endtask

  task automatic t_sub;
    apply(5'd1, 8'h50, 8'h00, 8'hB0, 4'b0001);
    expect4("R2 borrow overflow", 8'hA0, 8'hB0, 4'b1100, 4'b1111);
    apply(5'd1, 8'h50, 8'h00, 8'h10, 4'b0001);
    expect4("R2 no borrow", 8'h40, 8'h10, 4'b0001, 4'b1111);
  endtask

  task automatic t_logic;
    apply(5'd2, 8'hF0, 8'h00, 8'h0F, 4'b0101);
    expect4("R3 and", 8'h00, 8'h0F, 4'b0111, 4'b1010);
    apply(5'd3, 8'hF0, 8'h00, 8'h0F, 4'b0101);
    expect4("R3 or", 8'hFF, 8'h0F, 4'b1101, 4'b1010);
    apply(5'd4, 8'hFF, 8'h00, 8'hFF, 4'b0000);
    expect4("R3 xor", 8'h00, 8'hFF, 4'b0010, 4'b1010);
  endtask

  task automatic t_shift;
    apply(5'd5, 8'h00, 8'h00, 8'h80, 4'b0000);
    expect4("R4 shift left", 8'h00, 8'h00, 4'b0011, 4'b1011);
    apply(5'd6, 8'h00, 8'h00, 8'h81, 4'b1000);
    expect4("R4 shift right clears N", 8'h40, 8'h40, 4'b0001, 4'b1011);
  endtask

  task automatic t_rotate;
    apply(5'd7, 8'h00, 8'h00, 8'h40, 4'b0001);
    expect4("R5 rotate left", 8'h81, 8'h81, 4'b1000, 4'b1011);
    apply(5'd8, 8'h00, 8'h00, 8'h01, 4'b0001);
    expect4("R5 rotate right", 8'h80, 8'h80, 4'b1001, 4'b1011);
  endtask

  task automatic t_compare;
    apply(5'd9, 8'h10, 8'h00, 8'h10, 4'b0100);
    expect4("R6 compare equal", 8'h10, 8'h10, 4'b0111, 4'b1011);
    apply(5'd9, 8'h10, 8'h00, 8'h20, 4'b0000);
    expect4("R6 compare below", 8'h10, 8'h20, 4'b1000, 4'b1011);
  endtask

  task automatic t_bittest;
    apply(5'd10, 8'h0F, 8'h00, 8'hC0, 4'b0001);
    expect4("R7 bit test", 8'h0F, 8'hC0, 4'b1111, 4'b1110);
  endtask

  task automatic t_incdec;
    apply(5'd11, 8'h00, 8'h00, 8'hFF, 4'b0001);
    expect4("R8 inc wrap", 8'h00, 8'h00, 4'b0011, 4'b1010);
    apply(5'd12, 8'h00, 8'h00, 8'h00, 4'b0001);
    expect4("R8 dec wrap", 8'hFF, 8'hFF, 4'b1001, 4'b1010);
  endtask

  task automatic t_fused_step;
    apply(5'd13, 8'h05, 8'h00, 8'h06, 4'b0000);
    expect4("R9 dec then compare", 8'h05, 8'h05, 4'b0011, 4'b1011);
    apply(5'd14, 8'h10, 8'h00, 8'h0F, 4'b0001);
    expect4("R9 inc then subtract", 8'h00, 8'h10, 4'b0011, 4'b1111);
  endtask

  task automatic t_fused_shift;
    apply(5'd15, 8'h01, 8'h00, 8'h80, 4'b0000);
    expect4("R10 shift-or", 8'h01, 8'h00, 4'b0001, 4'b1011);
    apply(5'd16, 8'hFF, 8'h00, 8'h80, 4'b0001);
    expect4("R10 rotate-and", 8'h01, 8'h01, 4'b0001, 4'b1011);
    apply(5'd17, 8'h01, 8'h00, 8'h03, 4'b0000);
    expect4("R10 shift-xor", 8'h00, 8'h01, 4'b0011, 4'b1011);
    apply(5'd18, 8'h10, 8'h00, 8'h03, 4'b0000);
    expect4("R10 rotate-add", 8'h12, 8'h01, 4'b0000, 4'b1111);
  endtask

  task automatic t_load_store;
    apply(5'd19, 8'h33, 8'h00, 8'h80, 4'b0000);
    expect4("R11 load both", 8'h80, 8'h80, 4'b1000, 4'b1010);
    apply(5'd20, 8'hF0, 8'h3C, 8'h55, 4'b1011);
    expect4("R11 and-store", 8'hF0, 8'h30, 4'b1011, 4'b0000);
  endtask

  task automatic t_unused;
    for (int c = 21; c < 32; c++) begin
      apply(c[4:0], 8'h12, 8'h77, 8'h34, 4'b1010);
      expect4("R12 unused code", 8'h12, 8'h34, 4'b1010, 4'b0000);
    end
  endtask

  task automatic t_sweep;
    for (int ai = 0; ai < 256; ai += 17) begin
      for (int mi = 0; mi < 256; mi += 23) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int s = 0; s < 2; s++) begin
            int sa, sm, sr, ur;
            logic [7:0] r8;
            logic vv, cc;
            sa = (ai > 127) ? ai - 256 : ai;
            sm = (mi > 127) ? mi - 256 : mi;
            if (s == 0) begin
              ur = ai + mi + ci;
              sr = sa + sm + ci;
              cc = (ur > 255);
            end else begin
              ur = ai - mi - (1 - ci);
              sr = sa - sm - (1 - ci);
              cc = (ur >= 0);
            end
            r8 = ur[7:0];
            vv = (sr > 127) || (sr < -128);
            apply(s[4:0], ai[7:0], 8'h00, mi[7:0], {3'b000, ci[0]});
            expect4(s == 0 ? "R1 sweep" : "R2 sweep", r8, mi[7:0],
                    {r8[7], vv, (r8 == 8'h00), cc}, 4'b1111);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    op = '0; a = '0; x = '0; m = '0; fin = '0;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_rotate();
    t_compare();
    t_bittest();
    t_incdec();
    t_fused_step();
    t_fused_shift();
    t_load_store();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule